// File: doc/BRIEF.md
# Classifier Result Arbiter

This block finishes a classification lookup once a search key has been handed to an external match engine. It waits a programmable number of cycles and then polls a three-word result mailbox. Word 0 is re-read until its completion bit is set. Words 1 and 2 are then read once each. The three words report on three searches: a primary filter, a route table and an auxiliary filter. Each word carries a hit flag, a multi-hit flag, a priority and the byte address of a full result record.

When both the primary filter and the route table hit, the block compares their priorities. The filter's priority comes from its own word. The route priority is one configured value shared by every route. The winner becomes the primary result. The auxiliary filter produces a second, independent result. For every valid result the block fetches the three-word record from result memory. It then reports both results with a one-cycle completion pulse.

A poll limit guards the mailbox. If the completion bit never appears, the block gives up, reports a timeout and marks both results invalid. The mailbox and the result memory are simple request/response ports. Each request is a one-cycle pulse, and its response arrives any number of cycles later.

Top module: `lkup_result_arb`

## Requirements
- R1: Each mailbox word is laid out as follows: [31] completion, [30] hit, [29] multi-hit, [28:21] priority, [20:0] byte address of the full record, whose bits [1:0] are zero. Index 0 is the primary filter, index 1 the route table and index 2 the auxiliary filter.
- R2: `start` is accepted at a rising edge while the block is idle. The first mailbox request (`mb_rd` with `mb_idx` = 0) is raised on the (`wait_cycles`+1)-th rising edge after that accepting edge.
- R3: Index 0 is requested again after each response whose completion bit is 0. Index 1 and then index 2 are requested exactly once, and only after a response with the completion bit set. At most one mailbox request is outstanding at a time.
- R4: When both filter and route hit, the filter wins if its priority is greater than or equal to `route_prio`; otherwise the route wins. A tie goes to the filter. The route word's own priority field has no effect. `pri_from_route` is 1 exactly when the route was chosen.
- R5: When only one of filter and route hits, that one is the primary result. When neither hits, `pri_valid` is 0.
- R6: `aux_valid` equals the auxiliary hit flag, regardless of the auxiliary priority field.
- R7: For each valid result the block issues three memory reads at word addresses A, A+1 and A+2, where A is byte address [20:2]. The primary result is read before the auxiliary one. The words are returned with A at bits [31:0] and A+2 at bits [95:64]. No reads are issued for invalid results.
- R8: `pri_mhit` is the multi-hit flag of the selected primary source (0 when no primary result). `aux_mhit` is the auxiliary multi-hit flag when the auxiliary filter hits (0 otherwise).
- R9: After POLL_LIMIT index-0 responses without the completion bit, the block raises `timeout` and reports both results invalid. It issues no index-1/2 or memory reads in that case. A completion bit on the POLL_LIMIT-th response is a success.
- R10: After reset, all request, flag and result outputs are 0. `busy` is high from the edge that accepts `start` until `done` rises. `done` is a one-cycle pulse. The result outputs hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Key issued; begin a lookup |
| wait_cycles | input | WAIT_W | Delay before the first poll |
| route_prio | input | 8 | Priority shared by all routes |
| mb_rd | output | 1 | Mailbox read request pulse |
| mb_idx | output | 2 | Mailbox word index |
| mb_rvalid | input | 1 | Mailbox response valid |
| mb_rdata | input | 32 | Mailbox response word |
| mem_rd | output | 1 | Result memory read request pulse |
| mem_addr | output | 19 | Result memory word address |
| mem_rvalid | input | 1 | Memory response valid |
| mem_rdata | input | 32 | Memory response word |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Poll limit exhausted on the last lookup |
| pri_valid | output | 1 | Primary result valid |
| pri_from_route | output | 1 | Primary result came from the route table |
| pri_mhit | output | 1 | Multi-hit flag of the primary source |
| aux_valid | output | 1 | Auxiliary result valid |
| aux_mhit | output | 1 | Auxiliary multi-hit flag |
| pri_data | output | 96 | Fetched primary full record |
| aux_data | output | 96 | Fetched auxiliary full record |

## Verification
The completion bit and the exhaustion of the poll budget can arrive in the same mailbox response. That happens when the completion bit first appears on the POLL_LIMIT-th read of word 0. The bench provokes it with a responder that sets the bit on exactly that read. It also runs a case where the bit would only appear one read later. In the first case the bench expects a normal completion with words 1 and 2 read and records fetched, and no timeout. In the second it expects a timeout, both results invalid, and zero reads beyond the POLL_LIMIT polls.

// File: rtl/lkup_arb_pkg.sv
package lkup_arb_pkg;
  localparam int unsigned PRIO_W    = 8;
  localparam int unsigned RA_W      = 21;
  localparam int unsigned WA_W      = RA_W - 2;
  localparam int unsigned MB_W      = 32;
  localparam int unsigned RES_WORDS = 3;
  localparam int unsigned RES_W     = MB_W * RES_WORDS;

  typedef struct packed {
    logic              done;
    logic              hit;
    logic              mhit;
    logic [PRIO_W-1:0] prio;
    logic [RA_W-1:0]   addr;
  } mb_word_t;

  typedef enum logic [2:0] {
    PL_IDLE, PL_WAIT, PL_PREQ, PL_PRSP, PL_WREQ, PL_WRSP, PL_FIN
  } poll_st_t;

  typedef enum logic [1:0] {
    FE_IDLE, FE_REQ, FE_RSP, FE_FIN
  } fetch_st_t;
endpackage

// File: rtl/lkup_mbox_poller.sv
module lkup_mbox_poller
  import lkup_arb_pkg::*;
#(
  parameter int unsigned WAIT_W     = 8,
  parameter int unsigned POLL_LIMIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WAIT_W-1:0] wait_cycles,
  output logic              mb_rd,
  output logic [1:0]        mb_idx,
  input  logic              mb_rvalid,
  input  logic [MB_W-1:0]   mb_rdata,
  output logic              busy,
  output logic              fin,
  output logic              tmo,
  output mb_word_t          w0,
  output mb_word_t          w1,
  output mb_word_t          w2
);
  localparam int unsigned CNT_W = $clog2(POLL_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST_POLL = CNT_W'(POLL_LIMIT - 1);

  poll_st_t          st_q, st_d;
  logic [WAIT_W-1:0] wcnt_q, wcnt_d;
  logic [CNT_W-1:0]  pcnt_q, pcnt_d;
  logic [1:0]        idx_q, idx_d;
  logic              tmo_q, tmo_d;
  mb_word_t          w0_q, w1_q, w2_q;
  logic              w0_en, w1_en, w2_en;
  mb_word_t          rsp;

  assign rsp = mb_word_t'(mb_rdata);

  always_comb begin
    st_d   = st_q;
    wcnt_d = wcnt_q;
    pcnt_d = pcnt_q;
    idx_d  = idx_q;
    tmo_d  = tmo_q;
    w0_en  = 1'b0;
    w1_en  = 1'b0;
    w2_en  = 1'b0;
    case (st_q)
      PL_IDLE: begin
        if (start) begin
          st_d   = PL_WAIT;
          wcnt_d = wait_cycles;
          pcnt_d = '0;
          tmo_d  = 1'b0;
        end
      end
      PL_WAIT: begin
        if (wcnt_q == '0) st_d = PL_PREQ;
        else              wcnt_d = wcnt_q - 1'b1;
      end
      PL_PREQ: st_d = PL_PRSP;
      PL_PRSP: begin
        if (mb_rvalid) begin
          if (rsp.done) begin
            w0_en = 1'b1;
            idx_d = 2'd1;
            st_d  = PL_WREQ;
          end else begin
            pcnt_d = pcnt_q + 1'b1;
            if (pcnt_q == LAST_POLL) begin
              tmo_d = 1'b1;
              st_d  = PL_FIN;
            end else begin
              st_d = PL_PREQ;
            end
          end
        end
      end
      PL_WREQ: st_d = PL_WRSP;
      PL_WRSP: begin
        if (mb_rvalid) begin
          if (idx_q == 2'd1) begin
            w1_en = 1'b1;
            idx_d = 2'd2;
            st_d  = PL_WREQ;
          end else begin
            w2_en = 1'b1;
            st_d  = PL_FIN;
          end
        end
      end
      PL_FIN:  st_d = PL_IDLE;
      default: st_d = PL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PL_IDLE;
      wcnt_q <= '0;
      pcnt_q <= '0;
      idx_q  <= '0;
      tmo_q  <= 1'b0;
      w0_q   <= '0;
      w1_q   <= '0;
      w2_q   <= '0;
    end else begin
      st_q   <= st_d;
      wcnt_q <= wcnt_d;
      pcnt_q <= pcnt_d;
      idx_q  <= idx_d;
      tmo_q  <= tmo_d;
      if (w0_en) w0_q <= rsp;
      if (w1_en) w1_q <= rsp;
      if (w2_en) w2_q <= rsp;
    end
  end

  assign mb_rd  = (st_q == PL_PREQ) || (st_q == PL_WREQ);
  assign mb_idx = (st_q == PL_PREQ) ? 2'd0 : idx_q;
  assign busy   = (st_q != PL_IDLE);
  assign fin    = (st_q == PL_FIN);
  assign tmo    = tmo_q;
  assign w0     = w0_q;
  assign w1     = w1_q;
  assign w2     = w2_q;

  // R3
  word_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_rd && mb_idx != 2'd0) |-> w0_q.done);

  // R3
  mbox_single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mb_rd |=> !mb_rd);

  // R9
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= CNT_W'(POLL_LIMIT));
endmodule

// File: rtl/lkup_prio_select.sv
module lkup_prio_select
  import lkup_arb_pkg::*;
(
  input  mb_word_t          pf_w,
  input  mb_word_t          rt_w,
  input  mb_word_t          ax_w,
  input  logic [PRIO_W-1:0] route_prio,
  output logic              pri_valid,
  output logic              pri_route,
  output logic              pri_mhit,
  output logic [WA_W-1:0]   pri_base,
  output logic              aux_valid,
  output logic              aux_mhit,
  output logic [WA_W-1:0]   aux_base
);
  logic filt_wins;
  logic unused_sel;

  assign filt_wins = (pf_w.prio >= route_prio);
  assign pri_valid = pf_w.hit | rt_w.hit;
  assign pri_route = rt_w.hit & ~(pf_w.hit & filt_wins);
  assign pri_mhit  = pri_route ? rt_w.mhit : (pf_w.hit & pf_w.mhit);
  assign pri_base  = pri_route ? rt_w.addr[RA_W-1:2] : pf_w.addr[RA_W-1:2];
  assign aux_valid = ax_w.hit;
  assign aux_mhit  = ax_w.hit & ax_w.mhit;
  assign aux_base  = ax_w.addr[RA_W-1:2];

  assign unused_sel = ^{pf_w.done, rt_w.done, ax_w.done, rt_w.prio, ax_w.prio,
                        pf_w.addr[1:0], rt_w.addr[1:0], ax_w.addr[1:0]};
endmodule

// File: rtl/lkup_full_fetch.sv
module lkup_full_fetch
  import lkup_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             pri_need,
  input  logic [WA_W-1:0]  pri_base,
  input  logic             aux_need,
  input  logic [WA_W-1:0]  aux_base,
  output logic             mem_rd,
  output logic [WA_W-1:0]  mem_addr,
  input  logic             mem_rvalid,
  input  logic [MB_W-1:0]  mem_rdata,
  output logic             busy,
  output logic             fin,
  output logic [RES_W-1:0] pri_data,
  output logic [RES_W-1:0] aux_data
);
  localparam logic [1:0] LAST_WORD = 2'(RES_WORDS - 1);

  fetch_st_t             st_q, st_d;
  logic                  slot_q, slot_d;
  logic [1:0]            word_q, word_d;
  logic [1:0]            need_q, need_d;
  logic [1:0][WA_W-1:0]  base_q, base_d;
  logic                  wr_en;
  logic [1:0][RES_W-1:0] slot_data;

  always_comb begin
    st_d   = st_q;
    slot_d = slot_q;
    word_d = word_q;
    need_d = need_q;
    base_d = base_q;
    case (st_q)
      FE_IDLE: begin
        if (go) begin
          need_d = {aux_need, pri_need};
          base_d = {aux_base, pri_base};
          word_d = '0;
          slot_d = ~pri_need;
          st_d   = (pri_need | aux_need) ? FE_REQ : FE_FIN;
        end
      end
      FE_REQ: st_d = FE_RSP;
      FE_RSP: begin
        if (mem_rvalid) begin
          if (word_q == LAST_WORD) begin
            word_d = '0;
            if (!slot_q && need_q[1]) begin
              slot_d = 1'b1;
              st_d   = FE_REQ;
            end else begin
              st_d = FE_FIN;
            end
          end else begin
            word_d = word_q + 1'b1;
            st_d   = FE_REQ;
          end
        end
      end
      FE_FIN:  st_d = FE_IDLE;
      default: st_d = FE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FE_IDLE;
      slot_q <= 1'b0;
      word_q <= '0;
      need_q <= '0;
      base_q <= '0;
    end else begin
      st_q   <= st_d;
      slot_q <= slot_d;
      word_q <= word_d;
      need_q <= need_d;
      base_q <= base_d;
    end
  end

  assign wr_en = (st_q == FE_RSP) && mem_rvalid;

  for (genvar s = 0; s < 2; s++) begin : g_slot
    for (genvar k = 0; k < RES_WORDS; k++) begin : g_word
      logic word_en;
      logic [MB_W-1:0] word_r;
      assign word_en = wr_en && (slot_q == 1'(s)) && (word_q == 2'(k));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       word_r <= '0;
        else if (word_en) word_r <= mem_rdata;
      end
      assign slot_data[s][k*MB_W +: MB_W] = word_r;
    end
  end

  assign pri_data = slot_data[0];
  assign aux_data = slot_data[1];
  assign mem_rd   = (st_q == FE_REQ);
  assign mem_addr = base_q[slot_q] + WA_W'(word_q);
  assign busy     = (st_q != FE_IDLE);
  assign fin      = (st_q == FE_FIN);

  // R7
  fetch_valid_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> need_q[slot_q]);

  // R7
  fetch_single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
endmodule

// File: rtl/lkup_result_arb.sv
module lkup_result_arb
  import lkup_arb_pkg::*;
#(
  parameter int unsigned WAIT_W     = 8,
  parameter int unsigned POLL_LIMIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WAIT_W-1:0] wait_cycles,
  input  logic [7:0]        route_prio,
  output logic              mb_rd,
  output logic [1:0]        mb_idx,
  input  logic              mb_rvalid,
  input  logic [31:0]       mb_rdata,
  output logic              mem_rd,
  output logic [18:0]       mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  output logic              pri_valid,
  output logic              pri_from_route,
  output logic              pri_mhit,
  output logic              aux_valid,
  output logic              aux_mhit,
  output logic [95:0]       pri_data,
  output logic [95:0]       aux_data
);
  mb_word_t        w0, w1, w2;
  logic            pl_busy, pl_fin, pl_tmo, fe_busy, fe_fin, fe_go;
  logic            sel_pv, sel_route, sel_pmh, sel_av, sel_amh;
  logic [WA_W-1:0] sel_pbase, sel_abase;
  logic            out_en;

  logic done_q, done_d, tmo_q, tmo_d, pv_q, pv_d, prt_q, prt_d;
  logic pmh_q, pmh_d, av_q, av_d, amh_q, amh_d;

  lkup_mbox_poller #(.WAIT_W(WAIT_W), .POLL_LIMIT(POLL_LIMIT)) u_poll (
    .clk(clk), .rst_n(rst_n), .start(start & ~fe_busy), .wait_cycles(wait_cycles),
    .mb_rd(mb_rd), .mb_idx(mb_idx), .mb_rvalid(mb_rvalid), .mb_rdata(mb_rdata),
    .busy(pl_busy), .fin(pl_fin), .tmo(pl_tmo), .w0(w0), .w1(w1), .w2(w2)
  );

  lkup_prio_select u_sel (
    .pf_w(w0), .rt_w(w1), .ax_w(w2), .route_prio(route_prio),
    .pri_valid(sel_pv), .pri_route(sel_route), .pri_mhit(sel_pmh), .pri_base(sel_pbase),
    .aux_valid(sel_av), .aux_mhit(sel_amh), .aux_base(sel_abase)
  );

  assign fe_go = pl_fin & ~pl_tmo;

  lkup_full_fetch u_fetch (
    .clk(clk), .rst_n(rst_n), .go(fe_go),
    .pri_need(sel_pv), .pri_base(sel_pbase), .aux_need(sel_av), .aux_base(sel_abase),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .busy(fe_busy), .fin(fe_fin), .pri_data(pri_data), .aux_data(aux_data)
  );

  assign out_en = fe_fin | (pl_fin & pl_tmo);

  always_comb begin
    done_d = out_en;
    tmo_d  = tmo_q;
    pv_d   = pv_q;
    prt_d  = prt_q;
    pmh_d  = pmh_q;
    av_d   = av_q;
    amh_d  = amh_q;
    if (out_en) begin
      tmo_d = pl_tmo;
      pv_d  = sel_pv    & ~pl_tmo;
      prt_d = sel_route & ~pl_tmo;
      pmh_d = sel_pmh   & ~pl_tmo;
      av_d  = sel_av    & ~pl_tmo;
      amh_d = sel_amh   & ~pl_tmo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
      pv_q   <= 1'b0;
      prt_q  <= 1'b0;
      pmh_q  <= 1'b0;
      av_q   <= 1'b0;
      amh_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      tmo_q  <= tmo_d;
      pv_q   <= pv_d;
      prt_q  <= prt_d;
      pmh_q  <= pmh_d;
      av_q   <= av_d;
      amh_q  <= amh_d;
    end
  end

  assign busy           = pl_busy | fe_busy;
  assign done           = done_q;
  assign timeout        = tmo_q;
  assign pri_valid      = pv_q;
  assign pri_from_route = prt_q;
  assign pri_mhit       = pmh_q;
  assign aux_valid      = av_q;
  assign aux_mhit       = amh_q;

  // R9
  tmo_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(timeout && (pri_valid || aux_valid)));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  route_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pri_from_route |-> pri_valid);

  // R9
  tmo_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_fin && pl_tmo) |=> !mem_rd);
endmodule

// File: tb/lkup_result_arb_bench.sv
module lkup_result_arb_bench;
  localparam int PL = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [7:0]  wait_cycles;
  logic [7:0]  route_prio;
  logic        mb_rd;
  logic [1:0]  mb_idx;
  logic        mb_rvalid;
  logic [31:0] mb_rdata;
  logic        mem_rd;
  logic [18:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        busy, done, timeout, pri_valid, pri_from_route, pri_mhit, aux_valid, aux_mhit;
  logic [95:0] pri_data, aux_data;

  always #4 clk = ~clk;

  lkup_result_arb #(.WAIT_W(8), .POLL_LIMIT(PL)) u_lkup_result_arb (
    .clk(clk), .rst_n(rst_n), .start(start), .wait_cycles(wait_cycles), .route_prio(route_prio),
    .mb_rd(mb_rd), .mb_idx(mb_idx), .mb_rvalid(mb_rvalid), .mb_rdata(mb_rdata),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .timeout(timeout), .pri_valid(pri_valid),
    .pri_from_route(pri_from_route), .pri_mhit(pri_mhit), .aux_valid(aux_valid),
    .aux_mhit(aux_mhit), .pri_data(pri_data), .aux_data(aux_data)
  );

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // scenario controls
  logic        pf_hit, pf_mh, rt_hit, rt_mh, ax_hit, ax_mh;
  logic [7:0]  pf_prio, rt_pf, ax_pf;
  logic [20:0] pf_a, rt_a, ax_a;
  int          pbd, mb_lat, mem_lat;
  int          mb_reads0, mb_reads12, mem_reads;
  int unsigned first_rd_cyc;
  int          n_chk = 0, n_fail = 0;

  function automatic logic [31:0] mfn(input logic [18:0] a);
    return {a[12:0], ~a} ^ 32'h5A5A0F0F;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // mailbox responder (R1 layout)
  initial begin
    mb_rvalid = 1'b0;
    mb_rdata  = '0;
    forever begin
      @(negedge clk);
      while (mb_rd === 1'b1) begin
        logic [31:0] d;
        if (mb_idx == 2'd0) begin
          mb_reads0++;
          if (mb_reads0 == 1) first_rd_cyc = cyc;
          d = {(mb_reads0 > pbd), pf_hit, pf_mh, pf_prio, pf_a};
        end else if (mb_idx == 2'd1) begin
          mb_reads12++;
          d = {1'b1, rt_hit, rt_mh, rt_pf, rt_a};
        end else begin
          mb_reads12++;
          d = {1'b1, ax_hit, ax_mh, ax_pf, ax_a};
        end
        repeat (mb_lat) @(negedge clk);
        mb_rvalid = 1'b1;
        mb_rdata  = d;
        @(negedge clk);
        mb_rvalid = 1'b0;
        mb_rdata  = '0;
      end
    end
  end

  // result memory responder
  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    forever begin
      @(negedge clk);
      while (mem_rd === 1'b1) begin
        logic [31:0] d;
        mem_reads++;
        d = mfn(mem_addr);
        repeat (mem_lat) @(negedge clk);
        mem_rvalid = 1'b1;
        mem_rdata  = d;
        @(negedge clk);
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R10 watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  task automatic do_txn(input int w, input bit exp_tmo);
    int unsigned sc;
    int guard;
    logic pfw, e_pv, e_rt, e_pmh;
    logic [20:0] e_a;
    logic [18:0] pa, xa;
    logic [95:0] e_pd, e_xd;
    mb_reads0 = 0; mb_reads12 = 0; mem_reads = 0; first_rd_cyc = 0;
    @(negedge clk);
    wait_cycles = 8'(w);
    start = 1'b1;
    sc = cyc;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10 busy after start", 96'(busy), 96'd1);
    guard = 0;
    while (done !== 1'b1 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 5000) begin
      chk(1'b0, "R10 done never rose", 96'd0, 96'd1);
      return;
    end
    // R2: start driven at sc, accepted at next edge, request w+1 edges later
    chk(first_rd_cyc - sc == 32'(w + 2), "R2 first poll timing", 96'(first_rd_cyc - sc), 96'(w + 2));
    pfw   = (pf_prio >= route_prio);
    e_pv  = pf_hit | rt_hit;
    e_rt  = rt_hit & ~(pf_hit & pfw);
    e_pmh = e_rt ? rt_mh : (pf_hit & pf_mh);
    e_a   = e_rt ? rt_a : pf_a;
    pa    = e_a[20:2];
    xa    = ax_a[20:2];
    e_pd  = {mfn(pa + 19'd2), mfn(pa + 19'd1), mfn(pa)};
    e_xd  = {mfn(xa + 19'd2), mfn(xa + 19'd1), mfn(xa)};
    if (exp_tmo) begin
      chk(timeout == 1'b1, "R9 timeout raised", 96'(timeout), 96'd1);
      chk(pri_valid == 1'b0 && aux_valid == 1'b0, "R9 results invalid",
          96'({pri_valid, aux_valid}), 96'd0);
      chk(mb_reads0 == PL, "R9 poll count", 96'(mb_reads0), 96'(PL));
      chk(mb_reads12 == 0 && mem_reads == 0, "R9 no further reads",
          96'(mb_reads12 + mem_reads), 96'd0);
    end else begin
      chk(timeout == 1'b0, "R9 no timeout", 96'(timeout), 96'd0);
      chk(mb_reads0 == pbd + 1, "R3 word0 polls", 96'(mb_reads0), 96'(pbd + 1));
      chk(mb_reads12 == 2, "R3 words 1,2 read once", 96'(mb_reads12), 96'd2);
      chk(pri_valid == e_pv, "R5 pri_valid", 96'(pri_valid), 96'(e_pv));
      chk(pri_from_route == e_rt, "R4 priority pick", 96'(pri_from_route), 96'(e_rt));
      chk(aux_valid == ax_hit, "R6 aux_valid", 96'(aux_valid), 96'(ax_hit));
      chk(pri_mhit == e_pmh && aux_mhit == (ax_hit & ax_mh), "R8 multi-hit flags",
          96'({pri_mhit, aux_mhit}), 96'({e_pmh, ax_hit & ax_mh}));
      chk(mem_reads == 3 * (int'(e_pv) + int'(ax_hit)), "R7 memory read count",
          96'(mem_reads), 96'(3 * (int'(e_pv) + int'(ax_hit))));
      if (e_pv) chk(pri_data == e_pd, "R7 primary record", pri_data, e_pd);
      if (ax_hit) chk(aux_data == e_xd, "R7 auxiliary record", aux_data, e_xd);
    end
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R10 done pulse ends", 96'({done, busy}), 96'd0);
    chk(pri_valid == (e_pv & ~exp_tmo) && timeout == exp_tmo, "R10 outputs held",
        96'({pri_valid, timeout}), 96'({e_pv & ~exp_tmo, exp_tmo}));
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    wait_cycles = '0;
    route_prio = '0;
    pbd = 0; mb_lat = 1; mem_lat = 1;
    pf_hit = 0; pf_mh = 0; rt_hit = 0; rt_mh = 0; ax_hit = 0; ax_mh = 0;
    pf_prio = 0; rt_pf = 0; ax_pf = 0; pf_a = 0; rt_a = 0; ax_a = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk({busy, done, timeout, mb_rd, mem_rd, pri_valid, aux_valid} == 7'd0, "R10 reset outputs",
        96'({busy, done, timeout, mb_rd, mem_rd, pri_valid, aux_valid}), 96'd0);
    rst_n = 1'b1;

    for (int hm = 0; hm < 8; hm++) begin
      for (int pi = 0; pi < 4; pi++) begin
        for (int ri = 0; ri < 3; ri++) begin
          int n;
          n = hm * 12 + pi * 3 + ri;
          pf_hit = hm[0]; rt_hit = hm[1]; ax_hit = hm[2];
          pf_mh  = pi[0]; rt_mh = ri[0] ^ hm[0]; ax_mh = hm[0];
          case (pi)
            0: pf_prio = 8'd0;
            1: pf_prio = 8'd127;
            2: pf_prio = 8'd200;
            default: pf_prio = 8'd255;
          endcase
          case (ri)
            0: route_prio = 8'd0;
            1: route_prio = 8'd127;
            default: route_prio = 8'd255;
          endcase
          rt_pf = 8'd255 - pf_prio;   // R4: ignored
          ax_pf = 8'h33;              // R6: ignored
          pf_a = {19'(n * 7 + 3), 2'b00};
          rt_a = {19'(n * 11 + 500), 2'b00};
          ax_a = {19'(19'h7FFFF - 19'(n)), 2'b00};
          pbd = n % 4;
          mb_lat = 1 + n % 3;
          mem_lat = 1 + n % 2;
          do_txn(n % 5, 1'b0);
        end
      end
    end

    // R9 corner: completion on the last permitted poll
    pf_hit = 1; rt_hit = 1; ax_hit = 1; pf_prio = 8'd10; route_prio = 8'd10;
    pbd = PL - 1;
    do_txn(3, 1'b0);
    // R9 corner: completion would come one poll too late
    pbd = PL;
    do_txn(2, 1'b0 | 1'b1);
    // R9 never completes
    pbd = 1000;
    do_txn(0, 1'b1);
    // recovery after timeout, long wait (R2)
    pbd = 1; pf_prio = 8'd9; ax_hit = 0;
    do_txn(200, 1'b0);

    summary();
    $finish;
  end
endmodule